// File: doc/BRIEF.md
# Two-Sided Mailbox Register Bank

This block is a byte-wide register bank shared by two agents: a host and a management controller. Each agent has its own simple register port with address, write enable, write data and read data. Through these ports both agents reach the same sixteen message bytes, two status bytes, one control byte per side and four interrupt-enable bytes. Reads are combinational. Writes land on the next clock edge.

Every write to a message byte also sets a sticky status bit. Either agent clears a status bit by writing a one to its position. Each side drives a level interrupt. That interrupt is the OR of the status bits enabled for that side, plus a doorbell bit in that side's control byte. An agent rings the peer's doorbell by writing the ping bit of its own control byte. The receiving side clears the doorbell by writing bit 7 of its control byte, and it can hide the doorbell from its interrupt with a mask bit.

Top module: `mbx_regs`

## Requirements
- R1: Offsets 0x00 to 0x0F are message bytes. Either side can write them and both sides can read them. Read data follows the address combinationally, and a written value is readable after the clock edge that takes the write.
- R2: Offset 0x10 is status byte 0 and offset 0x11 is status byte 1. A write from either side clears every status bit where the write data holds a one. Bits written as zero keep their value.
- R3: A write to message byte n sets a status bit. For n from 0 to 7 it sets bit n of 0x10. For n from 8 to 15 it sets bit n-8 of 0x11. So a write to 0x0D sets 0x11 bit 5 (response), and a write to 0x0F sets 0x11 bit 7 (attention).
- R4: Offsets 0x14 and 0x15 are the controller enables for status bytes 0 and 1, and 0x16 and 0x17 are the host enables. All four are plain read/write bytes. Each side's interrupt is high while any status bit and its enable bit for that side are both one.
- R5: 0x12 is the controller control byte and 0x13 is the host control byte, with bit 0 = ping, bit 1 = mask and bit 7 = pending. Writing bit 0 as one to one side's control byte sets bit 7 of the other side's control byte. Bit 0 always reads as zero.
- R6: A control-byte write stores data bit 1 as that byte's mask and clears that byte's pending bit when data bit 7 is one. A pending bit adds to its own side's interrupt only while that side's mask is zero.
- R7: When a set event and a clear hit the same status bit or pending bit in one cycle, the bit ends up set.
- R8: When both sides write the same offset in one cycle, the controller's data is the one acted on. A message-byte status set event still occurs.
- R9: Offsets 0x18 and above read as zero, and writes to them change nothing.
- R10: After reset every register reads zero and both interrupts are low.
- R11: An interrupt stays high in the cycle that presents the clearing write. It is low after the clock edge that takes that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| c_addr | input | AW | Controller register offset |
| c_we | input | 1 | Controller write enable |
| c_wdata | input | 8 | Controller write data |
| c_rdata | output | 8 | Controller read data, combinational from c_addr |
| h_addr | input | AW | Host register offset |
| h_we | input | 1 | Host write enable |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, combinational from h_addr |
| c_irq | output | 1 | Level interrupt to the controller |
| h_irq | output | 1 | Level interrupt to the host |

## Verification
Results have two timings. Read data is due in the same cycle as the address. Every effect of a write is due only after the next rising edge: the stored byte, a status set or clear, a doorbell, and an interrupt rising or falling.

The bench drives inputs on the falling edge. It reads results one time unit later for directed checks, or at the following falling edge when comparing against its behavioural model. Each comparison therefore sees the state after exactly one rising edge. One check samples an interrupt before that edge, to show that the fall does not come early.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int unsigned REG_DW  = 8;
   localparam int unsigned N_MSG   = 16;
   localparam int unsigned N_REG   = 24;
   localparam int unsigned OFS_ST0  = 16;
   localparam int unsigned OFS_ST1  = 17;
   localparam int unsigned OFS_CCTL = 18;
   localparam int unsigned OFS_HCTL = 19;
   localparam int unsigned OFS_EN   = 20;
   localparam int unsigned N_EN     = 4;
   localparam int unsigned CTL_PING = 0;
   localparam int unsigned CTL_MASK = 1;
   localparam int unsigned CTL_PEND = 7;
   localparam int unsigned SIDE_C   = 0;
   localparam int unsigned SIDE_H   = 1;
endpackage

// File: rtl/mbx_wr_arb.sv
module mbx_wr_arb #(
   parameter int unsigned AW   = 5,
   parameter int unsigned DW   = 8,
   parameter int unsigned NREG = 24
) (
   input  logic                         c_we,
   input  logic [AW-1:0]                c_addr,
   input  logic [DW-1:0]                c_wdata,
   input  logic                         h_we,
   input  logic [AW-1:0]                h_addr,
   input  logic [DW-1:0]                h_wdata,
   output logic [NREG-1:0]              wr,
   output logic [NREG-1:0][DW-1:0]      wd
);
   if ((2 ** AW) < NREG) begin : g_bad_aw
      $error("mbx_wr_arb: AW too small for register count");
   end

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic c_hit, h_hit;
      assign c_hit = c_we && (c_addr == AW'(r));
      assign h_hit = h_we && (h_addr == AW'(r));
      assign wr[r] = c_hit | h_hit;
      assign wd[r] = c_hit ? c_wdata : h_wdata;
   end
endmodule

// File: rtl/mbx_msg_bank.sv
module mbx_msg_bank #(
   parameter int unsigned DW   = 8,
   parameter int unsigned NMSG = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NMSG-1:0]         wr,
   input  logic [NMSG-1:0][DW-1:0] wd,
   output logic [NMSG-1:0][DW-1:0] q
);
   for (genvar i = 0; i < NMSG; i++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     q[i] <= '0;
         else if (wr[i]) q[i] <= wd[i];
      end
   end
endmodule

// File: rtl/mbx_status.sv
module mbx_status #(
   parameter int unsigned DW = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2*DW-1:0]      set_ev,
   input  logic [1:0]           clr_we,
   input  logic [1:0][DW-1:0]   clr_d,
   output logic [2*DW-1:0]      st
);
   for (genvar b = 0; b < 2; b++) begin : g_byte
      logic [DW-1:0] clr_m, set_m;
      assign clr_m = clr_we[b] ? clr_d[b] : '0;
      assign set_m = set_ev[b*DW +: DW];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st[b*DW +: DW] <= '0;
         else        st[b*DW +: DW] <= (st[b*DW +: DW] & ~clr_m) | set_m;
      end
   end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl #(
   parameter int unsigned DW = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         wr,
   input  logic [1:0][DW-1:0] wd,
   output logic [1:0]         pend,
   output logic [1:0]         mask
);
   import mbx_pkg::*;

   for (genvar s = 0; s < 2; s++) begin : g_side
      logic ping_in, clr_own;
      assign ping_in = wr[1-s] && wd[1-s][CTL_PING];
      assign clr_own = wr[s] && wd[s][CTL_PEND];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend[s] <= 1'b0;
            mask[s] <= 1'b0;
         end else begin
            pend[s] <= (pend[s] & ~clr_own) | ping_in;
            if (wr[s]) mask[s] <= wd[s][CTL_MASK];
         end
      end
   end
endmodule

// File: rtl/mbx_regs.sv
module mbx_regs #(
   parameter int unsigned AW = 5,
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] c_addr,
   input  logic          c_we,
   input  logic [DW-1:0] c_wdata,
   output logic [DW-1:0] c_rdata,
   input  logic [AW-1:0] h_addr,
   input  logic          h_we,
   input  logic [DW-1:0] h_wdata,
   output logic [DW-1:0] h_rdata,
   output logic          c_irq,
   output logic          h_irq
);
   import mbx_pkg::*;

   localparam int unsigned NMSG   = N_MSG;
   localparam int unsigned NREG   = N_REG;
   localparam int unsigned MSG_AW = $clog2(NMSG);

   if (DW != REG_DW || NMSG != 2 * DW) begin : g_bad_dw
      $error("mbx_regs: status mapping requires 8-bit registers");
   end

   logic [NREG-1:0]          wr;
   logic [NREG-1:0][DW-1:0]  wd;
   logic [NMSG-1:0][DW-1:0]  msg_q;
   logic [2*DW-1:0]          st_q;
   logic [1:0]               pend_q, mask_q;
   logic [N_EN-1:0][DW-1:0]  en_q;

   mbx_wr_arb #(.AW(AW), .DW(DW), .NREG(NREG)) u_arb (
      .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata),
      .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
      .wr(wr), .wd(wd)
   );

   mbx_msg_bank #(.DW(DW), .NMSG(NMSG)) u_msg (
      .clk(clk), .rst_n(rst_n),
      .wr(wr[NMSG-1:0]), .wd(wd[NMSG-1:0]), .q(msg_q)
   );

   mbx_status #(.DW(DW)) u_st (
      .clk(clk), .rst_n(rst_n),
      .set_ev(wr[NMSG-1:0]),
      .clr_we(wr[OFS_ST1:OFS_ST0]), .clr_d(wd[OFS_ST1:OFS_ST0]),
      .st(st_q)
   );

   mbx_ctrl #(.DW(DW)) u_ctl (
      .clk(clk), .rst_n(rst_n),
      .wr(wr[OFS_HCTL:OFS_CCTL]), .wd(wd[OFS_HCTL:OFS_CCTL]),
      .pend(pend_q), .mask(mask_q)
   );

   for (genvar e = 0; e < N_EN; e++) begin : g_en
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              en_q[e] <= '0;
         else if (wr[OFS_EN+e])   en_q[e] <= wd[OFS_EN+e];
      end
   end

   // interrupt lines: enabled status plus unmasked doorbell of that side
   assign c_irq = (|(st_q[DW-1:0] & en_q[0])) | (|(st_q[2*DW-1:DW] & en_q[1]))
                | (pend_q[SIDE_C] & ~mask_q[SIDE_C]);
   assign h_irq = (|(st_q[DW-1:0] & en_q[2])) | (|(st_q[2*DW-1:DW] & en_q[3]))
                | (pend_q[SIDE_H] & ~mask_q[SIDE_H]);

   // read multiplexer, one copy per port
   logic [1:0][AW-1:0] rd_addr;
   logic [1:0][DW-1:0] rd_val;
   assign rd_addr = {h_addr, c_addr};

   for (genvar p = 0; p < 2; p++) begin : g_rd
      always_comb begin
         rd_val[p] = '0;
         if (rd_addr[p] < AW'(NMSG)) begin
            rd_val[p] = msg_q[rd_addr[p][MSG_AW-1:0]];
         end else if (rd_addr[p] == AW'(OFS_ST0)) begin
            rd_val[p] = st_q[DW-1:0];
         end else if (rd_addr[p] == AW'(OFS_ST1)) begin
            rd_val[p] = st_q[2*DW-1:DW];
         end else if (rd_addr[p] == AW'(OFS_CCTL)) begin
            rd_val[p][CTL_PEND] = pend_q[SIDE_C];
            rd_val[p][CTL_MASK] = mask_q[SIDE_C];
         end else if (rd_addr[p] == AW'(OFS_HCTL)) begin
            rd_val[p][CTL_PEND] = pend_q[SIDE_H];
            rd_val[p][CTL_MASK] = mask_q[SIDE_H];
         end else begin
            for (int e = 0; e < N_EN; e++) begin
               if (rd_addr[p] == AW'(OFS_EN + e)) rd_val[p] = en_q[e];
            end
         end
      end
   end

   assign c_rdata = rd_val[0];
   assign h_rdata = rd_val[1];
endmodule

// File: rtl/mbx_regs_chk.sv
module mbx_regs_chk #(
   parameter int unsigned AW = 5,
   parameter int unsigned DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] c_addr,
   input logic          c_we,
   input logic [DW-1:0] c_wdata,
   input logic [DW-1:0] c_rdata,
   input logic [AW-1:0] h_addr,
   input logic          h_we,
   input logic [DW-1:0] h_wdata,
   input logic          c_irq,
   input logic [2*DW-1:0] st,
   input logic [1:0]    pend
);
   import mbx_pkg::*;

   logic c_flag_wr, h_flag_wr, c_resp_wr, h_resp_wr, h_hi_msg_wr;
   assign c_flag_wr   = c_we && (c_addr == AW'(15));
   assign h_flag_wr   = h_we && (h_addr == AW'(15));
   assign c_resp_wr   = c_we && (c_addr == AW'(13));
   assign h_resp_wr   = h_we && (h_addr == AW'(13));
   assign h_hi_msg_wr = h_we && (h_addr >= AW'(8)) && (h_addr < AW'(N_MSG));

   AST_FLAG_SETS_ATTN: assert property (@(posedge clk) disable iff (!rst_n)
      (c_flag_wr || h_flag_wr) |=> st[15]); // R3
   AST_RESP_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (c_resp_wr || h_resp_wr) |=> st[13]); // R3
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (c_we && c_addr == AW'(OFS_ST1) && !h_hi_msg_wr)
      |=> ((st[2*DW-1:DW] & $past(c_wdata)) == '0)); // R2
   AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (c_flag_wr && h_we && h_addr == AW'(OFS_ST1) && h_wdata[7]) |=> st[15]); // R7
   AST_PING_REACHES_PEER: assert property (@(posedge clk) disable iff (!rst_n)
      (h_we && h_addr == AW'(OFS_HCTL) && h_wdata[CTL_PING]
       && !(c_we && c_addr == AW'(OFS_HCTL))) |=> pend[SIDE_C]); // R5
   AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      c_irq |-> (st != '0 || pend[SIDE_C])); // R4
   AST_UNUSED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (c_addr >= AW'(N_REG)) |-> (c_rdata == '0)); // R9
endmodule

bind mbx_regs mbx_regs_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .c_addr(c_addr), .c_we(c_we), .c_wdata(c_wdata), .c_rdata(c_rdata),
   .h_addr(h_addr), .h_we(h_we), .h_wdata(h_wdata),
   .c_irq(c_irq), .st(st_q), .pend(pend_q)
);

// File: tb/test_mbx_regs.sv
module test_mbx_regs;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [AW-1:0] c_addr = '0, h_addr = '0;
   logic c_we = 1'b0, h_we = 1'b0;
   logic [7:0] c_wdata = '0, h_wdata = '0;
   logic [7:0] c_rdata, h_rdata;
   logic c_irq, h_irq;

   always #(CLK_PERIOD/2) clk = ~clk;

   mbx_regs #(.AW(AW)) i_mbx_regs (
      .clk(clk), .rst_n(rst_n),
      .c_addr(c_addr), .c_we(c_we), .c_wdata(c_wdata), .c_rdata(c_rdata),
      .h_addr(h_addr), .h_we(h_we), .h_wdata(h_wdata), .h_rdata(h_rdata),
      .c_irq(c_irq), .h_irq(h_irq)
   );

   int n_chk = 0, n_err = 0;

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   // behavioural reference model (index 0 = controller, 1 = host)
   logic [7:0] m_msg [16];
   logic [15:0] m_st;
   logic [7:0] m_en [4];
   bit m_mask [2];
   bit m_pend [2];

   function automatic logic [7:0] m_read(int a);
      case (a)
         16: return m_st[7:0];
         17: return m_st[15:8];
         18: return {m_pend[0], 5'b0, m_mask[0], 1'b0};
         19: return {m_pend[1], 5'b0, m_mask[1], 1'b0};
         20, 21, 22, 23: return m_en[a-20];
         default: return (a < 16) ? m_msg[a] : 8'h00;
      endcase
   endfunction

   function automatic bit m_irq(int s);
      bit v;
      v = (|(m_st[7:0] & m_en[2*s])) | (|(m_st[15:8] & m_en[2*s+1]));
      return v | (m_pend[s] & !m_mask[s]);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) m_msg[i] = 8'h00;
         for (int i = 0; i < 4; i++) m_en[i] = 8'h00;
         m_st = '0; m_mask[0] = 0; m_mask[1] = 0; m_pend[0] = 0; m_pend[1] = 0;
      end else begin
         logic [15:0] setv, clrv;
         bit clr_p [2];
         bit ping [2];
         int ca, ha;
         setv = '0; clrv = '0;
         clr_p[0] = 0; clr_p[1] = 0; ping[0] = 0; ping[1] = 0;
         ca = int'(c_addr); ha = int'(h_addr);
         for (int side = 0; side < 2; side++) begin
            int a;
            logic [7:0] d;
            bit act;
            a   = (side == 0) ? ca : ha;
            d   = (side == 0) ? c_wdata : h_wdata;
            act = (side == 0) ? c_we : (h_we && !(c_we && ca == ha));
            if (side == 1 && h_we && ha < 16) setv[ha] = 1'b1;
            if (act) begin
               if (a < 16) begin m_msg[a] = d; setv[a] = 1'b1; end
               else if (a == 16) clrv[7:0]  = clrv[7:0]  | d;
               else if (a == 17) clrv[15:8] = clrv[15:8] | d;
               else if (a == 18 || a == 19) begin
                  m_mask[a-18] = d[1];
                  if (d[7]) clr_p[a-18] = 1;
                  if (d[0]) ping[19-a] = 1;
               end else if (a < 24) m_en[a-20] = d;
            end
         end
         m_st = (m_st & ~clrv) | setv;
         for (int s = 0; s < 2; s++) m_pend[s] = (m_pend[s] & !clr_p[s]) | ping[s];
      end
   end

   function automatic string tag_of(int a);
      if (a < 16) return "R1";
      if (a < 18) return "R2";
      if (a < 20) return "R5";
      if (a < 24) return "R4";
      return "R9";
   endfunction

   task automatic cmp_all();
      chk({tag_of(int'(c_addr)), " model c_rdata"}, c_rdata, m_read(int'(c_addr)));
      chk({tag_of(int'(h_addr)), " model h_rdata"}, h_rdata, m_read(int'(h_addr)));
      chk("R4 model c_irq", {7'b0, c_irq}, {7'b0, m_irq(0)});
      chk("R4 model h_irq", {7'b0, h_irq}, {7'b0, m_irq(1)});
   endtask

   task automatic drive(int ca, bit cw, logic [7:0] cd, int ha, bit hw, logic [7:0] hd);
      @(negedge clk);
      cmp_all();
      c_addr = AW'(ca); c_we = cw; c_wdata = cd;
      h_addr = AW'(ha); h_we = hw; h_wdata = hd;
   endtask

   task automatic peek(int a, logic [7:0] exp, string tag);
      @(negedge clk);
      cmp_all();
      c_addr = AW'(a); h_addr = AW'(a); c_we = 0; h_we = 0;
      #1;
      chk({tag, " c side"}, c_rdata, exp);
      chk({tag, " h side"}, h_rdata, exp);
   endtask

   task automatic irqs(bit ec, bit eh, string tag);
      chk({tag, " c_irq"}, {7'b0, c_irq}, {7'b0, ec});
      chk({tag, " h_irq"}, {7'b0, h_irq}, {7'b0, eh});
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10 reset state
      peek(8'h00, 8'h00, "R10"); peek(8'h11, 8'h00, "R10"); peek(8'h13, 8'h00, "R10");
      irqs(0, 0, "R10");
      // R1 / R3: response and attention bytes
      drive(0, 0, 0, 8'h0D, 1, 8'hA5);
      peek(8'h0D, 8'hA5, "R1"); peek(8'h11, 8'h20, "R3");
      drive(8'h0F, 1, 8'h3C, 0, 0, 0);
      peek(8'h0F, 8'h3C, "R1"); peek(8'h11, 8'hA0, "R3");
      // R4 enable raises host interrupt
      drive(0, 0, 0, 8'h17, 1, 8'h80);
      peek(8'h17, 8'h80, "R4"); irqs(0, 1, "R4");
      // R11 / R2 clear timing
      drive(0, 0, 0, 8'h11, 1, 8'h80);
      #1 irqs(0, 1, "R11 before edge");
      peek(8'h11, 8'h20, "R2"); irqs(0, 0, "R11");
      drive(8'h11, 1, 8'h00, 0, 0, 0);
      peek(8'h11, 8'h20, "R2 zeros keep");
      // R7 set beats clear
      drive(8'h0F, 1, 8'h01, 8'h11, 1, 8'hFF);
      peek(8'h11, 8'h80, "R7");
      drive(0, 0, 0, 8'h17, 1, 8'h00);
      drive(0, 0, 0, 8'h11, 1, 8'hFF);
      peek(8'h11, 8'h00, "R2");
      // R5 ping host -> controller
      drive(0, 0, 0, 8'h13, 1, 8'h03);
      peek(8'h12, 8'h80, "R5"); peek(8'h13, 8'h02, "R5"); irqs(1, 0, "R5");
      // R7 on pending: clear and ping together
      drive(8'h12, 1, 8'h80, 8'h13, 1, 8'h01);
      peek(8'h12, 8'h80, "R7 pend"); peek(8'h13, 8'h00, "R6");
      drive(8'h12, 1, 8'h80, 0, 0, 0);
      peek(8'h12, 8'h00, "R6"); irqs(0, 0, "R6");
      // R6 mask on host side
      drive(0, 0, 0, 8'h13, 1, 8'h02);
      drive(8'h12, 1, 8'h01, 0, 0, 0);
      peek(8'h13, 8'h82, "R5"); irqs(0, 0, "R6 masked");
      drive(0, 0, 0, 8'h13, 1, 8'h00);
      peek(8'h13, 8'h80, "R6"); irqs(0, 1, "R6 unmasked");
      drive(0, 0, 0, 8'h13, 1, 8'h80);
      peek(8'h13, 8'h00, "R6"); irqs(0, 0, "R6 cleared");
      // R8 same-offset collision
      drive(8'h05, 1, 8'h11, 8'h05, 1, 8'h22);
      peek(8'h05, 8'h11, "R8"); peek(8'h10, 8'h20, "R8");
      // R9 unused offsets
      drive(8'h1A, 1, 8'hFF, 8'h1F, 1, 8'hFF);
      peek(8'h1A, 8'h00, "R9"); peek(8'h1F, 8'h00, "R9");
      peek(8'h10, 8'h20, "R9"); peek(8'h14, 8'h00, "R9");
      // R4 / R11 controller side
      drive(8'h14, 1, 8'h20, 0, 0, 0);
      peek(8'h14, 8'h20, "R4"); irqs(1, 0, "R4");
      drive(0, 0, 0, 8'h10, 1, 8'h20);
      peek(8'h10, 8'h00, "R2"); irqs(0, 0, "R11");
      // random traffic against the model
      for (int i = 0; i < 4000; i++) begin
         int ca, ha;
         ca = (($urandom % 4) == 0) ? int'($urandom % 32) : int'($urandom % 24);
         ha = (($urandom % 4) == 0) ? ca : int'($urandom % 24);
         drive(ca, 1'($urandom % 2), 8'($urandom), ha, 1'($urandom % 2), 8'($urandom));
      end
      drive(0, 0, 0, 0, 0, 0);
      drive(0, 0, 0, 0, 0, 0);
      finish_run();
   end
endmodule